// File: doc/BRIEF.md
# Read-Strobed I2C Line Port

This block lets software drive a two-wire I2C bus through a small window of read-only memory space on a 68000-style bus. The processor only reads from the window. The two lowest address bits of each qualifying read set the new clock and data line levels. No write strobe and no write data are involved, so the port keeps working in an address range where write cycles never reach the board.

The window covers four consecutive byte addresses at the top of the lower 48K ROM area. These are $BFDC to $BFDF. The block checks A14 low, A5 low, A4 high, the ROM output-enable strobe and an external fine-decode input. The fine-decode input stands for all the remaining address bits. During a read in the window, data bit 0 returns the level sensed on the SDA pin. SCL is a push-pull output that is always driven. SDA is open-drain: the block can only pull it low or release it, and never drives it high.

All inputs are registered in a single clock domain before use. A qualifying access updates the lines once, on the rising edge of the registered hit condition.

Top module: `i2c_rdport`

## Requirements
- R1: While reset is asserted and when it is released, SCL is high, SDA is not pulled (`sda_drive_low` = 0) and no data bit is enabled.
- R2: A qualifying access needs all of the following: `bus_addr[14]` = 0, `bus_addr[5]` = 0, `bus_addr[4]` = 1, `rom_oe` = 1 and `fine_dec` = 1. `dbus_oe[0]` rises one clock after such inputs are presented and falls one clock after they go away.
- R3: At the start of a qualifying access, `scl_out` takes the value of `bus_addr[0]`. It changes two clocks after the access inputs are first presented.
- R4: At the start of a qualifying access, SDA is pulled low (`sda_drive_low` = 1) when `bus_addr[1]` = 0 and released when `bus_addr[1]` = 1, with the same timing as R3.
- R5: An access that fails any one qualifier in R2 leaves `scl_out` and `sda_drive_low` unchanged and keeps `dbus_oe[0]` low.
- R6: While an access stays qualified, a change of address is ignored. New line levels take effect only after the qualified condition has dropped and then returns.
- R7: While `dbus_oe[0]` is high, `dbus_out[0]` shows the `sda_in` level delayed by SYNC_STAGES clocks (default 2).
- R8: `dbus_oe` bits 1 and up are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Processor byte address |
| rom_oe | input | 1 | ROM output-enable strobe (active level set by STROBE_POL) |
| fine_dec | input | 1 | External decode of the remaining address bits, active high |
| sda_in | input | 1 | Sensed level of the SDA pin |
| scl_out | output | 1 | SCL line level, always driven |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| dbus_out | output | DATA_W | Read data; bit 0 carries the SDA level |
| dbus_oe | output | DATA_W | Per-bit output enable of the read data |

## Verification
A corrupted line latch shows up at `scl_out` or `sda_drive_low` as soon as it happens. It then stays wrong until the next qualifying access overwrites it. A stuck hit flag is worse. If the edge detect misses the rising edge, an access leaves the lines at their old values. If the edge detect fires again during the access, a mid-access address change leaks through. Either fault is visible two clocks after the access inputs appear. A wrong qualifier decode shows at `dbus_oe[0]` one clock after the inputs, and on the line outputs one clock after that.

// File: rtl/i2c_rdport_pkg.sv
package i2c_rdport_pkg;

   // Address bits whose position the behaviour depends on
   localparam int unsigned BIT_SCL_SEL = 0;
   localparam int unsigned BIT_SDA_SEL = 1;
   localparam int unsigned BIT_QUAL_HI = 4;   // must be 1
   localparam int unsigned BIT_QUAL_LO = 5;   // must be 0
   localparam int unsigned BIT_QUAL_TOP = 14; // must be 0

   typedef struct packed {
      logic scl;
      logic sda_low;
   } line_state_t;

   localparam line_state_t LINES_RELEASED = '{scl: 1'b1, sda_low: 1'b0};

   function automatic logic window_match(input logic top_bit,
                                         input logic lo_bit,
                                         input logic hi_bit,
                                         input logic strobe_on,
                                         input logic dec_on);
      return !top_bit && !lo_bit && hi_bit && strobe_on && dec_on;
   endfunction

endpackage

// File: rtl/i2c_rdport_capture.sv
module i2c_rdport_capture
   import i2c_rdport_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter bit          STROBE_POL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              rom_oe,
   input  logic              fine_dec,
   output logic              hit,
   output logic              sel_scl,
   output logic              sel_sda
);

   logic strobe_q, dec_q, top_q, lo_q, hi_q, scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         dec_q    <= 1'b0;
         top_q    <= 1'b1;
         lo_q     <= 1'b1;
         hi_q     <= 1'b0;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         strobe_q <= (rom_oe == STROBE_POL);
         dec_q    <= fine_dec;
         top_q    <= bus_addr[BIT_QUAL_TOP];
         lo_q     <= bus_addr[BIT_QUAL_LO];
         hi_q     <= bus_addr[BIT_QUAL_HI];
         scl_q    <= bus_addr[BIT_SCL_SEL];
         sda_q    <= bus_addr[BIT_SDA_SEL];
      end
   end

   assign hit     = window_match(top_q, lo_q, hi_q, strobe_q, dec_q);
   assign sel_scl = scl_q;
   assign sel_sda = sda_q;

   logic unused_addr_bits;
   assign unused_addr_bits = ^bus_addr;

endmodule

// File: rtl/i2c_rdport_sync.sv
module i2c_rdport_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else if (i == 0) chain[i] <= d;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_rdport_latch.sv
module i2c_rdport_latch
   import i2c_rdport_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hit,
   input  logic        sel_scl,
   input  logic        sel_sda,
   output line_state_t lines
);

   logic hit_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines    <= LINES_RELEASED;
         hit_prev <= 1'b0;
      end else begin
         hit_prev <= hit;
         if (hit && !hit_prev) begin
            lines.scl     <= sel_scl;
            lines.sda_low <= ~sel_sda;
         end
      end
   end

endmodule

// File: rtl/i2c_rdport.sv
module i2c_rdport
   import i2c_rdport_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          STROBE_POL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              rom_oe,
   input  logic              fine_dec,
   input  logic              sda_in,
   output logic              scl_out,
   output logic              sda_drive_low,
   output logic [DATA_W-1:0] dbus_out,
   output logic [DATA_W-1:0] dbus_oe
);

   localparam int unsigned UPPER_W = DATA_W - 1;

   generate
      if (ADDR_W <= BIT_QUAL_TOP) begin : g_bad_addr_w
         $error("i2c_rdport: ADDR_W too small for qualifier bits");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("i2c_rdport: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("i2c_rdport: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic        hit, sel_scl, sel_sda, sda_sensed;
   line_state_t lines;

   i2c_rdport_capture #(
      .ADDR_W     (ADDR_W),
      .STROBE_POL (STROBE_POL)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .rom_oe   (rom_oe),
      .fine_dec (fine_dec),
      .hit      (hit),
      .sel_scl  (sel_scl),
      .sel_sda  (sel_sda)
   );

   i2c_rdport_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .sel_scl (sel_scl),
      .sel_sda (sel_sda),
      .lines   (lines)
   );

   i2c_rdport_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sda_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sda_in),
      .q     (sda_sensed)
   );

   assign scl_out       = lines.scl;
   assign sda_drive_low = lines.sda_low;
   assign dbus_out      = {{UPPER_W{1'b0}}, sda_sensed};
   assign dbus_oe       = {{UPPER_W{1'b0}}, hit};

endmodule

// File: rtl/i2c_rdport_chk.sv
module i2c_rdport_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              rom_oe,
   input logic              fine_dec,
   input logic              scl_out,
   input logic              sda_drive_low,
   input logic [DATA_W-1:0] dbus_oe
);

   logic in_window;
   assign in_window = !bus_addr[14] && !bus_addr[5] && bus_addr[4] && rom_oe && fine_dec;

   AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (scl_out && !sda_drive_low && !dbus_oe[0])); // R1

   AST_WINDOW_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (dbus_oe[0] == $past(in_window))); // R2

   AST_SCL_FROM_A0: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe[0] && !$past(dbus_oe[0])) |=> (scl_out == $past(bus_addr[0], 2))); // R3

   AST_SDA_FROM_A1: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe[0] && !$past(dbus_oe[0])) |=> (sda_drive_low == !$past(bus_addr[1], 2))); // R4

   AST_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !dbus_oe[0] |=> ($stable(scl_out) && $stable(sda_drive_low))); // R5

   AST_ONCE_PER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe[0] && $past(dbus_oe[0])) |=> ($stable(scl_out) && $stable(sda_drive_low))); // R6

endmodule

bind i2c_rdport i2c_rdport_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_addr      (bus_addr),
   .rom_oe        (rom_oe),
   .fine_dec      (fine_dec),
   .scl_out       (scl_out),
   .sda_drive_low (sda_drive_low),
   .dbus_oe       (dbus_oe)
);

// File: tb/tb_i2c_rdport.sv
module tb_i2c_rdport;

   localparam int unsigned ADDR_W = 16;
   localparam int unsigned DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              rom_oe = 1'b0;
   logic              fine_dec = 1'b0;
   logic              ext_sda = 1'b1;
   logic              sda_in;
   logic              scl_out, sda_drive_low;
   logic [DATA_W-1:0] dbus_out, dbus_oe;

   always #2 clk = ~clk;

   // open-drain pin: pulled up unless the block or an external device pulls it low
   assign sda_in = sda_drive_low ? 1'b0 : ext_sda;

   i2c_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rom_oe(rom_oe),
      .fine_dec(fine_dec), .sda_in(sda_in), .scl_out(scl_out),
      .sda_drive_low(sda_drive_low), .dbus_out(dbus_out), .dbus_oe(dbus_oe)
   );

   typedef enum {K_SCL, K_SDALOW, K_D0OE, K_D0, K_UPOE} kind_t;
   typedef struct {
      kind_t kind;
      logic  val;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   compared = 0;
   int   mismatched = 0;
   bit   done = 1'b0;

   task automatic push_exp(input kind_t k, input logic v, input string r);
      exp_t e;
      e.kind = k;
      e.val  = v;
      e.req  = r;
      exp_q.push_back(e);
   endtask

   task automatic expect_lines(input logic scl, input logic sdalow, input string r);
      push_exp(K_SCL, scl, r);
      push_exp(K_SDALOW, sdalow, r);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic [ADDR_W-1:0] a, input logic oe, input logic dec);
      bus_addr = a;
      rom_oe   = oe;
      fine_dec = dec;
   endtask

   task automatic idle();
      drive('0, 1'b0, 1'b0);
   endtask

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         exp_t e;
         logic act;
         wait (exp_q.size() != 0);
         e = exp_q.pop_front();
         case (e.kind)
            K_SCL:    act = scl_out;
            K_SDALOW: act = sda_drive_low;
            K_D0OE:   act = dbus_oe[0];
            K_D0:     act = dbus_out[0];
            default:  act = |dbus_oe[DATA_W-1:1];
         endcase
         compared++;
         if (act !== e.val) begin
            mismatched++;
            $display("FAIL %s: %s actual %b expected %b", e.req, e.kind.name(), act, e.val);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] bad_addr [5];
      logic              bad_oe   [5];
      logic              bad_dec  [5];

      // R1: reset state
      step(3);
      expect_lines(1'b1, 1'b0, "R1");
      push_exp(K_D0OE, 1'b0, "R1");
      push_exp(K_UPOE, 1'b0, "R8");
      rst_n = 1'b1;
      step(2);
      expect_lines(1'b1, 1'b0, "R1");

      // $BFDC: SCL low, SDA pulled
      drive(16'hBFDC, 1'b1, 1'b1);
      step(1);
      push_exp(K_D0OE, 1'b1, "R2");
      push_exp(K_UPOE, 1'b0, "R8");
      expect_lines(1'b1, 1'b0, "R3");
      step(4);
      expect_lines(1'b0, 1'b1, "R3 R4");
      push_exp(K_D0, 1'b0, "R7");
      idle();
      step(1);
      push_exp(K_D0OE, 1'b0, "R2");
      step(2);

      // $BFDF: both released; D0 follows pin
      drive(16'hBFDF, 1'b1, 1'b1);
      step(5);
      expect_lines(1'b1, 1'b0, "R3 R4");
      push_exp(K_D0, 1'b1, "R7");
      ext_sda = 1'b0;
      step(3);
      push_exp(K_D0, 1'b0, "R7");
      push_exp(K_UPOE, 1'b0, "R8");
      ext_sda = 1'b1;
      idle();
      step(3);

      // $BFDD then $BFDE
      drive(16'hBFDD, 1'b1, 1'b1);
      step(3);
      expect_lines(1'b1, 1'b1, "R3 R4");
      idle();
      step(2);
      drive(16'hBFDE, 1'b1, 1'b1);
      step(3);
      expect_lines(1'b0, 1'b0, "R3 R4");
      idle();
      step(2);

      // R5: each qualifier broken alone, address would otherwise set 1/1
      bad_addr = '{16'hFFDD, 16'hBFFD, 16'hBFCD, 16'hBFDD, 16'hBFDD};
      bad_oe   = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
      bad_dec  = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
      for (int i = 0; i < 5; i++) begin
         drive(bad_addr[i], bad_oe[i], bad_dec[i]);
         step(1);
         push_exp(K_D0OE, 1'b0, "R2");
         step(3);
         expect_lines(1'b0, 1'b0, "R5");
         idle();
         step(2);
      end

      // R6: address change inside a held access is ignored
      drive(16'hBFDF, 1'b1, 1'b1);
      step(3);
      expect_lines(1'b1, 1'b0, "R6");
      drive(16'hBFDC, 1'b1, 1'b1);
      step(4);
      expect_lines(1'b1, 1'b0, "R6");
      idle();
      step(1);
      drive(16'hBFDC, 1'b1, 1'b1);
      step(3);
      expect_lines(1'b0, 1'b1, "R6");
      idle();
      step(3);

      #1;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule